// File: doc/BRIEF.md
# Keyboard Port Trap SMI Logic

This block sits beside a narrow I/O bus and watches for accesses to the two legacy keyboard controller ports, the data port at 0060h and the command/status port at 0064h. Each of the four access kinds (data read, data write, command read, command write) sets its own sticky status flag. A level system management interrupt request is raised while any flagged event has its enable set. A USB interrupt input can also be routed to the same request.

The block also follows the three-step gate-A20 pass-through sequence: command D1h to port 0064h, one data byte to port 0060h, then FFh to port 0064h. The accesses of a recognised sequence are let through without being trapped. A read-only state bit shows that a sequence is in progress. Software can ask for any interrupt request that arises during a sequence to be held back until the sequence has ended.

Software reaches the block through a small register port with two registers: an 8-bit control register (select 0) and a 16-bit status register (select 1).

Top module: `kbc_trap_smi`

## Requirements
- R1: Only the full addresses 0060h and 0064h are decoded. Four events are recognised: 0060h read (index 0), 0060h write (index 1), 0064h read (index 2) and 0064h write (index 3). An access to any other address sets no flag.
- R2: Control bits 3:0 enable events 0 to 3. smi_req is high while a status flag is set and its enable bit is 1.
- R3: A status flag in status bit 8+index is set one cycle after its event, whether or not its enable bit is set.
- R4: Writing 1 to status bits 11:8 clears the matching flags. Writing 0 leaves a flag unchanged. All other status bits read 0 and ignore writes.
- R5: When control bit 4 is 1, a high usb_irq drives smi_req high in the same cycle.
- R6: When control bit 5 is 1, the sequence D1h written to 0064h, any write to 0060h, then FFh written to 0064h is tracked. Control bit 6 reads 1 from the first step until the sequence ends. It reads 0 whenever bit 5 was 0 in the previous cycle.
- R7: The three accesses of a tracked sequence set no status flag.
- R8: When control bit 7 is 1, smi_req is held low while a sequence is in progress. A condition that arose during the sequence is asserted once the sequence ends.
- R9: The control register resets to 00h. Bits 7:0, except bit 6, are read/write. Bit 6 is read-only. Register bits 15:8 read 0.
- R10: While a sequence is in progress, any other access to 0060h or 0064h ends the sequence. That access is trapped normally.
- R11: If an event and a write-1-to-clear of its flag fall in the same cycle, the flag ends up set.
- R12: smi_req is a level. It stays high until the causing flag is cleared or its enable is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O bus address |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_wdata | input | 8 | I/O write data |
| usb_irq | input | 1 | USB interrupt level |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| smi_req | output | 1 | Level SMI request |

## Verification
Two functions can fall in the same cycle: a trap event setting a flag, and a software write-one-to-clear aimed at that same flag. The bench drives a port access and a status write with the matching bit in one cycle. It expects the flag to stay set and smi_req to stay high. A second coincidence is a USB interrupt that arrives in the middle of a pass-through sequence while deferral is on. The bench checks that smi_req stays low on every step and rises on the cycle after the closing FFh write.

// File: rtl/kbc_trap_pkg.sv
package kbc_trap_pkg;

    localparam int NUM_EV = 4;

    // event indexes: bit0 = write strobe, bit1 = command port
    localparam int EV_DATA_RD = 0;
    localparam int EV_DATA_WR = 1;
    localparam int EV_CMD_RD  = 2;
    localparam int EV_CMD_WR  = 3;

    typedef enum logic [1:0] {
        PT_IDLE = 2'd0,
        PT_CMD  = 2'd1,
        PT_DATA = 2'd2
    } pt_state_e;

    typedef struct packed {
        logic              defer_smi;  // bit 7
        logic              pt_busy;    // bit 6, read-only view
        logic              pt_en;      // bit 5
        logic              usb_en;     // bit 4
        logic [NUM_EV-1:0] trap_en;    // bits 3:0
    } ctrl_t;

    function automatic logic ev_is_write(input int idx);
        return idx[0];
    endfunction

    function automatic logic ev_is_cmd(input int idx);
        return idx[1];
    endfunction

endpackage

// File: rtl/kbc_io_decode.sv
module kbc_io_decode
    import kbc_trap_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] PORT_D = 16'h0060,
    parameter logic [15:0] PORT_C = 16'h0064
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic [NUM_EV-1:0] ev
);

    logic hit_d;
    logic hit_c;

    assign hit_d = (io_addr == ADDR_W'(PORT_D));
    assign hit_c = (io_addr == ADDR_W'(PORT_C));

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        logic port_hit;
        logic strobe;
        assign port_hit = ev_is_cmd(i)   ? hit_c : hit_d;
        assign strobe   = ev_is_write(i) ? io_wr : io_rd;
        assign ev[i]    = port_hit & strobe;
    end

endmodule

// File: rtl/kbc_a20_tracker.sv
module kbc_a20_tracker
    import kbc_trap_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] PORT_D    = 16'h0060,
    parameter logic [15:0] PORT_C    = 16'h0064,
    parameter logic [7:0]  OPEN_CMD  = 8'hD1,
    parameter logic [7:0]  CLOSE_CMD = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic              active,
    output logic              exempt
);

    pt_state_e st_q, st_n;
    logic hit_d, hit_c, port_rd, port_any;
    logic step_open, step_data, step_close;

    assign hit_d    = (io_addr == ADDR_W'(PORT_D));
    assign hit_c    = (io_addr == ADDR_W'(PORT_C));
    assign port_rd  = io_rd & (hit_d | hit_c);
    assign port_any = (io_rd | io_wr) & (hit_d | hit_c);

    assign step_open  = io_wr & hit_c & (io_wdata == OPEN_CMD)  & ~port_rd;
    assign step_data  = io_wr & hit_d & ~port_rd;
    assign step_close = io_wr & hit_c & (io_wdata == CLOSE_CMD) & ~port_rd;

    always_comb begin
        st_n   = st_q;
        exempt = 1'b0;
        if (!enable) begin
            st_n = PT_IDLE;
        end else begin
            case (st_q)
                PT_IDLE: begin
                    if (step_open) begin
                        st_n   = PT_CMD;
                        exempt = 1'b1;
                    end
                end
                PT_CMD: begin
                    if (step_data) begin
                        st_n   = PT_DATA;
                        exempt = 1'b1;
                    end else if (port_any) begin
                        st_n = PT_IDLE;
                    end
                end
                PT_DATA: begin
                    if (step_close) begin
                        st_n   = PT_IDLE;
                        exempt = 1'b1;
                    end else if (port_any) begin
                        st_n = PT_IDLE;
                    end
                end
                default: st_n = PT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PT_IDLE;
        else     st_q <= st_n;
    end

    assign active = (st_q != PT_IDLE);

endmodule

// File: rtl/kbc_trap_status.sv
module kbc_trap_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/kbc_trap_smi.sv
module kbc_trap_smi
    import kbc_trap_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          REG_W     = 16,
    parameter int          STAT_LSB  = 8,
    parameter logic [15:0] PORT_D    = 16'h0060,
    parameter logic [15:0] PORT_C    = 16'h0064,
    parameter logic [7:0]  OPEN_CMD  = 8'hD1,
    parameter logic [7:0]  CLOSE_CMD = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    input  logic              usb_irq,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              smi_req
);

    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t             ctrl_q;
    logic [NUM_EV-1:0] ev;
    logic [NUM_EV-1:0] ev_set;
    logic [NUM_EV-1:0] clr_mask;
    logic [NUM_EV-1:0] stat_flags;
    logic              pt_active;
    logic              pt_exempt;
    logic              smi_raw;
    ctrl_t             ctrl_view;

    // control register, bit 6 is never stored
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (reg_we && !reg_sel) begin
            ctrl_q         <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            ctrl_q.pt_busy <= 1'b0;
        end
    end

    kbc_io_decode #(
        .ADDR_W (ADDR_W),
        .PORT_D (PORT_D),
        .PORT_C (PORT_C)
    ) u_decode (
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .ev      (ev)
    );

    kbc_a20_tracker #(
        .ADDR_W    (ADDR_W),
        .PORT_D    (PORT_D),
        .PORT_C    (PORT_C),
        .OPEN_CMD  (OPEN_CMD),
        .CLOSE_CMD (CLOSE_CMD)
    ) u_tracker (
        .clk      (clk),
        .rst      (rst),
        .enable   (ctrl_q.pt_en),
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .active   (pt_active),
        .exempt   (pt_exempt)
    );

    assign ev_set   = ev & {NUM_EV{~pt_exempt}};
    assign clr_mask = (reg_we && reg_sel) ? reg_wdata[STAT_LSB +: NUM_EV] : '0;

    kbc_trap_status #(
        .N (NUM_EV)
    ) u_status (
        .clk   (clk),
        .rst   (rst),
        .set   (ev_set),
        .clr   (clr_mask),
        .flags (stat_flags)
    );

    always_comb begin
        ctrl_view         = ctrl_q;
        ctrl_view.pt_busy = pt_active;
        reg_rdata         = '0;
        if (reg_sel) reg_rdata[STAT_LSB +: NUM_EV] = stat_flags;
        else         reg_rdata[CTRL_W-1:0]         = ctrl_view;
    end

    assign smi_raw = (|(stat_flags & ctrl_q.trap_en)) | (ctrl_q.usb_en & usb_irq);
    assign smi_req = smi_raw & ~(ctrl_q.defer_smi & pt_active);

endmodule

// File: rtl/kbc_trap_smi_chk.sv
module kbc_trap_smi_chk
    import kbc_trap_pkg::*;
#(
    parameter int REG_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_EV-1:0] stat_flags,
    input logic [NUM_EV-1:0] clr_mask,
    input logic              pt_exempt,
    input logic              pt_active,
    input logic              pt_en,
    input logic              defer_en,
    input logic              smi_req,
    input logic              reg_sel,
    input logic [REG_W-1:0]  reg_rdata
);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(stat_flags) & ~$past(clr_mask)) & ~stat_flags) == '0)); // R4

    AST_EXEMPT_NO_SET: assert property (@(posedge clk) disable iff (rst)
        pt_exempt |=> ((stat_flags & ~$past(stat_flags)) == '0)); // R7

    AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (defer_en && pt_active) |-> !smi_req); // R8

    AST_PT_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pt_en |=> !pt_active); // R6

    always_comb begin
        if (!rst && reg_sel)
            AST_STAT_RSVD_ZERO: assert (reg_rdata[7:0] == 8'h00); // R4
        if (!rst && !reg_sel)
            AST_CTRL_UPPER_ZERO: assert (reg_rdata[15:8] == 8'h00); // R9
    end

endmodule

bind kbc_trap_smi kbc_trap_smi_chk #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stat_flags (stat_flags),
    .clr_mask   (clr_mask),
    .pt_exempt  (pt_exempt),
    .pt_active  (pt_active),
    .pt_en      (ctrl_q.pt_en),
    .defer_en   (ctrl_q.defer_smi),
    .smi_req    (smi_req),
    .reg_sel    (reg_sel),
    .reg_rdata  (reg_rdata)
);

// File: tb/tb_kbc_trap_smi.sv
module tb_kbc_trap_smi;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        usb_irq = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        smi_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    kbc_trap_smi dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .usb_irq(usb_irq), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smi_req(smi_req)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus access lasting one cycle; returns at the following falling edge
    task automatic io(input logic rd, input logic wr, input logic [15:0] a, input logic [7:0] d);
        io_rd = rd; io_wr = wr; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0; io_addr = 16'h0000;
    endtask

    task automatic regw(input logic sel, input logic [15:0] d);
        reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic regr(input logic sel, output logic [15:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [15:0] ev_addr(input int i);
        return i[1] ? 16'h0064 : 16'h0060;
    endfunction

    task automatic fire(input int i);
        io(~i[0], i[0], ev_addr(i), 8'h20);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state, R9
        regr(0, rd); check("R9 ctrl reset", rd, 16'h0000);
        regr(1, rd); check("R9 status reset", rd, 16'h0000);
        check("R9 smi reset", {15'b0, smi_req}, 16'h0000);

        // R9 read/write bits, bit 6 read-only
        regw(0, 16'hFFFF);
        regr(0, rd); check("R9 ctrl readback", rd, 16'h00BF);
        regw(0, 16'h0000);

        // R1 R2 R3 R12: every enable pattern against every event
        for (int en = 0; en < 16; en++) begin
            for (int i = 0; i < 4; i++) begin
                regw(1, 16'h0F00);
                regw(0, 16'(en));
                fire(i);
                regr(1, rd); check("R3 flag set", rd, 16'(1 << (8 + i)));
                check("R2 smi pairing", {15'b0, smi_req}, {15'b0, en[i]});
                repeat (2) @(negedge clk);
                check("R12 smi level held", {15'b0, smi_req}, {15'b0, en[i]});
            end
        end
        regw(0, 16'h0000);
        regw(1, 16'h0F00);

        // R1 near-miss addresses
        for (int k = 0; k < 6; k++) begin
            logic [15:0] a;
            a = (k == 0) ? 16'h0061 : (k == 1) ? 16'h0065 : (k == 2) ? 16'h0160 :
                (k == 3) ? 16'h8064 : (k == 4) ? 16'h0020 : 16'h0063;
            io(1'b1, 1'b0, a, 8'h00);
            io(1'b0, 1'b1, a, 8'hD1);
            regr(1, rd); check("R1 other address", rd, 16'h0000);
        end

        // R4 write-one-to-clear sweep with junk in other bits
        for (int m = 0; m < 16; m++) begin
            regw(1, 16'h0F00);
            for (int i = 0; i < 4; i++) fire(i);
            regw(1, 16'(m << 8) | 16'hF0FF);
            regr(1, rd); check("R4 w1c", rd, 16'(((~m) & 4'hF) << 8));
        end
        regw(1, 16'h0F00);

        // R5 USB routing
        for (int c = 0; c < 4; c++) begin
            regw(0, c[0] ? 16'h0010 : 16'h0000);
            usb_irq = c[1];
            #1;
            check("R5 usb smi", {15'b0, smi_req}, {15'b0, c[0] & c[1]});
            @(negedge clk);
        end
        usb_irq = 1'b0;

        // R6 R7 full sequence with all traps enabled
        regw(0, 16'h002F);
        io(1'b0, 1'b1, 16'h0064, 8'hD1);
        regr(0, rd); check("R6 busy after open", rd, 16'h006F);
        io(1'b0, 1'b1, 16'h0060, 8'hDF);
        regr(0, rd); check("R6 busy after data", rd, 16'h006F);
        io(1'b0, 1'b1, 16'h0064, 8'hFF);
        regr(0, rd); check("R6 idle after close", rd, 16'h002F);
        regr(1, rd); check("R7 no flags", rd, 16'h0000);
        check("R7 no smi", {15'b0, smi_req}, 16'h0000);

        // R6 with tracking off: the open write is trapped
        regw(0, 16'h000F);
        io(1'b0, 1'b1, 16'h0064, 8'hD1);
        regr(0, rd); check("R6 disabled no busy", rd, 16'h000F);
        regr(1, rd); check("R6 disabled trapped", rd, 16'h0800);
        regw(1, 16'h0F00);

        // R10 abort by a port read
        regw(0, 16'h002F);
        io(1'b0, 1'b1, 16'h0064, 8'hD1);
        io(1'b1, 1'b0, 16'h0060, 8'h00);
        regr(0, rd); check("R10 abort idle", rd, 16'h002F);
        regr(1, rd); check("R10 abort trapped", rd, 16'h0100);
        regw(1, 16'h0F00);
        // R10 abort by a wrong close byte
        io(1'b0, 1'b1, 16'h0064, 8'hD1);
        io(1'b0, 1'b1, 16'h0060, 8'h01);
        io(1'b0, 1'b1, 16'h0064, 8'hFE);
        regr(0, rd); check("R10 bad close idle", rd, 16'h002F);
        regr(1, rd); check("R10 bad close trapped", rd, 16'h0800);
        regw(1, 16'h0F00);

        // R8 deferral of a usb request raised mid-sequence
        regw(0, 16'h00B0);
        io(1'b0, 1'b1, 16'h0064, 8'hD1);
        usb_irq = 1'b1;
        #1; check("R8 held after open", {15'b0, smi_req}, 16'h0000);
        io(1'b0, 1'b1, 16'h0060, 8'h03);
        check("R8 held after data", {15'b0, smi_req}, 16'h0000);
        io(1'b0, 1'b1, 16'h0064, 8'hFF);
        check("R8 released at end", {15'b0, smi_req}, 16'h0001);
        usb_irq = 1'b0;
        // without deferral the request is immediate
        regw(0, 16'h0030);
        io(1'b0, 1'b1, 16'h0064, 8'hD1);
        usb_irq = 1'b1;
        #1; check("R8 no defer immediate", {15'b0, smi_req}, 16'h0001);
        usb_irq = 1'b0;
        io(1'b0, 1'b1, 16'h0060, 8'h03);
        io(1'b0, 1'b1, 16'h0064, 8'hFF);

        // R11 event and clear in the same cycle, for each event
        regw(0, 16'h000F);
        for (int i = 0; i < 4; i++) begin
            regw(1, 16'h0F00);
            io_rd = ~i[0]; io_wr = i[0]; io_addr = ev_addr(i); io_wdata = 8'h20;
            reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = 16'(1 << (8 + i));
            @(negedge clk);
            io_rd = 1'b0; io_wr = 1'b0; reg_we = 1'b0; reg_wdata = '0;
            regr(1, rd); check("R11 set wins", rd, 16'(1 << (8 + i)));
            check("R11 smi stays", {15'b0, smi_req}, 16'h0001);
        end
        regw(1, 16'h0F00);
        #1; check("R12 smi drops on clear", {15'b0, smi_req}, 16'h0000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule